// File: doc/BRIEF.md
# Memory Barrier Issue Gate

This block sits between an in-order instruction stream and the memory system of a core. Every cycle it is offered one operation: a load, a store, a barrier or a synchronization operation. It decides whether that operation may leave now or must wait. Two counters track how many loads and how many stores have issued and not yet completed. Completion arrives as single-cycle pulses from the memory side.

A barrier does not go to memory. The gate decodes it into a set of four ordering bits, each relating an earlier operation class to a later one. While the barrier is pending, only the later classes it restricts are stalled. Other traffic flows with no added latency. The barrier retires once the counters it depends on reach zero. A synchronization operation drains everything before it and then blocks everything behind it until memory acknowledges it.

Operations use a valid/ready handshake: an operation is taken in any cycle where `op_valid` and `op_ready` are both high. A stall holds `op_ready` low.

Top module: `mbg_issue_gate`

## Requirements
- R1: After reset both outstanding counts are zero, no barrier is pending and no synchronization is in flight, so `op_ready` is high for every operation kind.
- R2: The load count rises by one on each load issue and falls by one on each `ld_done` pulse. The store count does the same with stores and `st_done`. A rise and a fall in the same cycle leave the count unchanged. Counts are registered, so a completion pulse affects `op_ready` from the next cycle on.
- R3: `op_kind` codes are 0 load, 1 store, 2 barrier, 3 synchronization. A barrier with `fence_kind` 0 or 3 is a full barrier. While it is pending, later loads, stores, barriers and synchronizations stall until both counts are zero.
- R4: A barrier with `fence_kind` 1 orders stores only. While it is pending, later stores stall until the store count is zero, and loads issue freely.
- R5: A barrier with `fence_kind` 2 takes its ordering from `fence_mask`: bit 0 load→load, bit 1 load→store, bit 2 store→load, bit 3 store→store. Later loads stall if bit 0 or bit 2 is set. Later stores stall if bit 1 or bit 3 is set. The barrier needs the load count at zero if bit 0 or bit 1 is set, and the store count at zero if bit 2 or bit 3 is set.
- R6: With `fence_mask` = 4'b0101, later loads wait until both the load count and the store count are zero, while later stores issue past the barrier.
- R7: A barrier whose required counts are already zero when it is accepted leaves nothing pending. In the cycle its counts reach zero, a pending barrier stops stalling. Classes a barrier does not restrict see `op_ready` high in the same cycle.
- R8: Only one barrier is pending at a time. A further barrier stalls until the pending one retires.
- R9: A synchronization operation issues only when both counts are zero and no barrier is pending. After it issues, every operation stalls until `sync_done` pulses.
- R10: A class whose count is at its maximum (2^CNT_W−1) stalls, so the count never wraps.
- R11: An `ld_done` or `st_done` pulse while the matching count is zero, and a `sync_done` pulse with no synchronization in flight, have no effect.
- R12: `mem_ld_issue`, `mem_st_issue` and `mem_sync_issue` pulse exactly when an operation of that kind is taken. Taking a barrier pulses none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_kind | input | 2 | 0 load, 1 store, 2 barrier, 3 synchronization |
| fence_kind | input | 2 | Barrier flavour: 0/3 full, 1 store-only, 2 masked |
| fence_mask | input | 4 | Ordering bits of a masked barrier |
| op_ready | output | 1 | The offered operation may be taken this cycle |
| mem_ld_issue | output | 1 | A load is issued to memory |
| mem_st_issue | output | 1 | A store is issued to memory |
| mem_sync_issue | output | 1 | A synchronization is issued to memory |
| ld_done | input | 1 | One load has completed |
| st_done | input | 1 | One store has completed |
| sync_done | input | 1 | The synchronization in flight has completed |

## Verification
The hardest state to reach is a counter at its limit while a barrier is pending and another class is allowed to pass. Random completion rates that stay high never let fifteen loads pile up. The random stimulus therefore runs one phase with frequent completions and one where completions are rare, so counts climb to the ceiling. Directed sequences then pin the cycle-exact release of each barrier flavour: the masked 4'b0101 case, spurious completion pulses at a zero count, and a second barrier queued behind the first.

// File: rtl/mbg_pkg.sv
package mbg_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_SYNC  = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    FK_FULL  = 2'd0,
    FK_WRITE = 2'd1,
    FK_MASK  = 2'd2,
    FK_FULLX = 2'd3
  } fence_kind_e;

  // Ordering bits: earlier class -> later class. Cast from the 4-bit mask
  // gives ll = bit 0, ls = bit 1, sl = bit 2, ss = bit 3.
  typedef struct packed {
    logic ss;
    logic sl;
    logic ls;
    logic ll;
  } order_t;

  function automatic order_t fence_decode(input fence_kind_e k, input logic [3:0] m);
    order_t o;
    case (k)
      FK_WRITE: o = order_t'(4'b1000);
      FK_MASK:  o = order_t'(m);
      default:  o = order_t'(4'b1111);
    endcase
    return o;
  endfunction

  function automatic logic blocks_load(input order_t o);
    return o.ll | o.sl;
  endfunction

  function automatic logic blocks_store(input order_t o);
    return o.ls | o.ss;
  endfunction

  function automatic logic order_sat(input order_t o, input logic ld_zero,
                                     input logic st_zero);
    logic need_ld, need_st;
    need_ld = o.ll | o.ls;
    need_st = o.sl | o.ss;
    return (!need_ld || ld_zero) && (!need_st || st_zero);
  endfunction

endpackage

// File: rtl/mbg_outstanding_ctr.sv
module mbg_outstanding_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         at_max,
  output logic         is_zero
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] CMAX = '1;

  logic dec_eff;

  assign is_zero = (cnt == '0);
  assign at_max  = (cnt == CMAX);
  assign dec_eff = dec && !is_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && !dec_eff) begin
      cnt <= cnt + ONE;
    end else if (dec_eff && !inc) begin
      cnt <= cnt - ONE;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |-> !inc);

  assert_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(cnt));

  assert_zero_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_zero && !inc) |=> (cnt == '0));

endmodule

// File: rtl/mbg_fence_tracker.sv
module mbg_fence_tracker
  import mbg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fence_fire,
  input  order_t new_ord,
  input  logic   ld_zero,
  input  logic   st_zero,
  output logic   ld_hold,
  output logic   st_hold,
  output logic   fence_hold
);
  logic   pend;
  order_t ord;
  logic   sat_cur, sat_new, active;

  always_comb begin
    sat_cur    = order_sat(ord, ld_zero, st_zero);
    sat_new    = order_sat(new_ord, ld_zero, st_zero);
    active     = pend && !sat_cur;
    ld_hold    = active && blocks_load(ord);
    st_hold    = active && blocks_store(ord);
    fence_hold = active;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ord  <= '0;
    end else if (fence_fire) begin
      ord  <= new_ord;
      pend <= !sat_new;
    end else if (pend && sat_cur) begin
      pend <= 1'b0;
    end
  end

  assert_single_fence_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !fence_fire);

  assert_fence_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fence_fire) |=> pend);

endmodule

// File: rtl/mbg_issue_gate.sv
module mbg_issue_gate
  import mbg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  input  logic [1:0] fence_kind,
  input  logic [3:0] fence_mask,
  output logic       op_ready,
  output logic       mem_ld_issue,
  output logic       mem_st_issue,
  output logic       mem_sync_issue,
  input  logic       ld_done,
  input  logic       st_done,
  input  logic       sync_done
);
  localparam int NCLS = 2;  // class 0 loads, class 1 stores

  op_kind_e   kind;
  logic       fire, fence_fire;
  logic       sync_busy;
  logic       ld_hold, st_hold, fence_hold;
  logic [NCLS-1:0] cls_inc, cls_dec, cls_max, cls_zero;
  logic [CNT_W-1:0] cls_cnt [NCLS];
  order_t     new_ord;

  assign kind = op_kind_e'(op_kind);

  always_comb begin
    op_ready = 1'b0;
    if (!sync_busy) begin
      case (kind)
        OP_LOAD:  op_ready = !ld_hold && !cls_max[0];
        OP_STORE: op_ready = !st_hold && !cls_max[1];
        OP_FENCE: op_ready = !fence_hold;
        OP_SYNC:  op_ready = !fence_hold && cls_zero[0] && cls_zero[1];
        default:  op_ready = 1'b0;
      endcase
    end
  end

  assign fire           = op_valid && op_ready;
  assign mem_ld_issue   = fire && (kind == OP_LOAD);
  assign mem_st_issue   = fire && (kind == OP_STORE);
  assign mem_sync_issue = fire && (kind == OP_SYNC);
  assign fence_fire     = fire && (kind == OP_FENCE);
  assign new_ord        = fence_decode(fence_kind_e'(fence_kind), fence_mask);

  assign cls_inc = {mem_st_issue, mem_ld_issue};
  assign cls_dec = {st_done, ld_done};

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    mbg_outstanding_ctr #(.W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (cls_inc[c]),
      .dec     (cls_dec[c]),
      .cnt     (cls_cnt[c]),
      .at_max  (cls_max[c]),
      .is_zero (cls_zero[c])
    );
  end

  mbg_fence_tracker u_fence (
    .clk        (clk),
    .rst_n      (rst_n),
    .fence_fire (fence_fire),
    .new_ord    (new_ord),
    .ld_zero    (cls_zero[0]),
    .st_zero    (cls_zero[1]),
    .ld_hold    (ld_hold),
    .st_hold    (st_hold),
    .fence_hold (fence_hold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_busy <= 1'b0;
    end else if (mem_sync_issue) begin
      sync_busy <= 1'b1;
    end else if (sync_done) begin
      sync_busy <= 1'b0;
    end
  end

  assert_sync_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sync_issue |-> (cls_cnt[0] == '0) && (cls_cnt[1] == '0));

  assert_sync_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_busy |-> !(mem_ld_issue || mem_st_issue || mem_sync_issue));

  assert_one_issue_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_ld_issue, mem_st_issue, mem_sync_issue}));

  assert_load_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hold |-> !mem_ld_issue);

  assert_store_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_hold |-> !mem_st_issue);

  assert_sync_busy_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sync_issue |=> sync_busy);

endmodule

// File: tb/test_mbg_issue_gate.sv
`timescale 1ns/1ps
module test_mbg_issue_gate;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = '0, fence_kind = '0;
  logic [3:0] fence_mask = '0;
  logic ld_done = 1'b0, st_done = 1'b0, sync_done = 1'b0;
  logic op_ready, mem_ld_issue, mem_st_issue, mem_sync_issue;

  always #2.5 clk = ~clk;

  mbg_issue_gate #(.CNT_W(CW)) i_mbg_issue_gate (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .fence_kind(fence_kind), .fence_mask(fence_mask), .op_ready(op_ready),
    .mem_ld_issue(mem_ld_issue), .mem_st_issue(mem_st_issue),
    .mem_sync_issue(mem_sync_issue), .ld_done(ld_done), .st_done(st_done),
    .sync_done(sync_done)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  bit obs_ready;

  // Bench model state
  int m_ld = 0, m_st = 0;
  bit m_pend = 0, m_busy = 0;
  bit [3:0] m_ord = '0;  // bit0 LL, bit1 LS, bit2 SL, bit3 SS

  function automatic bit [3:0] ord_of(bit [1:0] fk, bit [3:0] m);
    if (fk == 2'd1) return 4'b1000;
    if (fk == 2'd2) return m;
    return 4'b1111;
  endfunction

  function automatic bit met(bit [3:0] o);
    bit wants_ld = o[0] || o[1];
    bit wants_st = o[2] || o[3];
    return (!wants_ld || m_ld == 0) && (!wants_st || m_st == 0);
  endfunction

  function automatic bit exp_ready(bit [1:0] k);
    bit stall = m_pend && !met(m_ord);
    if (m_busy) return 0;
    case (k)
      2'd0: return !(stall && (m_ord[0] || m_ord[2])) && m_ld < CMAX;
      2'd1: return !(stall && (m_ord[1] || m_ord[3])) && m_st < CMAX;
      2'd2: return !stall;
      default: return !stall && m_ld == 0 && m_st == 0;
    endcase
  endfunction

  task automatic check(bit cond, string tag, int got, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic drive(bit v, bit [1:0] k, bit [1:0] fk, bit [3:0] m,
                       bit ldd, bit std, bit syd, string tag);
    bit er, take;
    bit [3:0] ev, av;
    @(negedge clk);
    op_valid = v; op_kind = k; fence_kind = fk; fence_mask = m;
    ld_done = ldd; st_done = std; sync_done = syd;
    #1;
    er   = exp_ready(k);
    take = v && er;
    ev = {er, take && k == 2'd0, take && k == 2'd1, take && k == 2'd3};
    av = {op_ready, mem_ld_issue, mem_st_issue, mem_sync_issue};
    obs_ready = op_ready;
    check(av == ev, {tag, " R12 ready/issue"}, av, ev);
    // model update from pre-edge state
    if (take && k == 2'd2) begin
      m_ord = ord_of(fk, m);
      m_pend = !met(m_ord);
    end else if (m_pend && met(m_ord)) begin
      m_pend = 0;
    end
    if (take && k == 2'd3) m_busy = 1;
    else if (m_busy && syd) m_busy = 0;
    if (ldd && m_ld > 0) m_ld--;
    if (std && m_st > 0) m_st--;
    if (take && k == 2'd0) m_ld++;
    if (take && k == 2'd1) m_st++;
  endtask

  task automatic want(bit exp, string tag);
    check(obs_ready == exp, tag, obs_ready, exp);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  task automatic drain();
    for (int i = 0; i < 64; i++) begin
      if (m_ld == 0 && m_st == 0 && !m_busy && !m_pend) break;
      drive(0, 0, 0, 0, m_ld > 0, m_st > 0, m_busy, "drain");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, sync (strictest kind) ready, nothing issued
    drive(0, 2'd3, 0, 0, 0, 0, 0, "R1 reset sync ready");
    want(1, "R1 sync ready after reset");
    drive(0, 2'd0, 0, 0, 0, 0, 0, "R1 reset load ready");
    want(1, "R1 load ready after reset");

    // R3 / R2: full barrier behind one load
    drive(1, 2'd0, 0, 0, 0, 0, 0, "R2 load issue");
    drive(1, 2'd2, 2'd0, 0, 0, 0, 0, "R3 full fence");
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R3 store stalls");
    want(0, "R3 store behind full fence");
    drive(1, 2'd1, 0, 0, 1, 0, 0, "R2 done registered");
    want(0, "R2 completion acts next cycle");
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R7 store released");
    want(1, "R7 store issues in retire cycle");
    drain();

    // R4: store-only barrier
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R4 store issue");
    drive(1, 2'd2, 2'd1, 0, 0, 0, 0, "R4 write fence");
    drive(1, 2'd0, 0, 0, 0, 0, 0, "R4 load passes");
    want(1, "R4 load passes store fence");
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R4 store stalls");
    want(0, "R4 store behind store fence");
    drive(1, 2'd1, 0, 0, 0, 1, 0, "R4 st_done");
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R4 store released");
    want(1, "R4 store after store drain");
    drain();

    // R5 / R6: mask 0101
    drive(1, 2'd0, 0, 0, 0, 0, 0, "R6 load");
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R6 store");
    drive(1, 2'd2, 2'd2, 4'b0101, 0, 0, 0, "R6 masked fence");
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R6 store passes");
    want(1, "R6 later store passes");
    drive(1, 2'd0, 0, 0, 1, 1, 0, "R6 load waits");
    want(0, "R6 load waits with ld1 st2");
    drive(1, 2'd0, 0, 0, 0, 1, 0, "R5 load waits on store");
    want(0, "R5 load waits on remaining store");
    drive(1, 2'd0, 0, 0, 0, 0, 0, "R5 load released");
    want(1, "R5 load after both counts zero");
    drain();

    // R8: second barrier behind the first; R7 immediate barrier
    drive(1, 2'd0, 0, 0, 0, 0, 0, "R8 load");
    drive(1, 2'd2, 2'd3, 0, 0, 0, 0, "R8 full fence code 3");
    drive(1, 2'd2, 2'd0, 0, 1, 0, 0, "R8 second fence");
    want(0, "R8 second fence stalls");
    drive(1, 2'd2, 2'd0, 0, 0, 0, 0, "R8 second fence taken");
    want(1, "R8 second fence after retire");
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R7 no pending");
    want(1, "R7 fence with zero counts leaves nothing pending");
    drain();

    // R9: synchronization
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R9 store");
    drive(1, 2'd3, 0, 0, 0, 0, 0, "R9 sync waits");
    want(0, "R9 sync waits for store");
    drive(1, 2'd3, 0, 0, 0, 1, 0, "R9 sync waits 2");
    want(0, "R9 sync waits while count registered");
    drive(1, 2'd3, 0, 0, 0, 0, 0, "R9 sync issue");
    want(1, "R9 sync issues when drained");
    drive(1, 2'd0, 0, 0, 0, 0, 0, "R9 load blocked");
    want(0, "R9 load blocked by sync");
    drive(1, 2'd0, 0, 0, 0, 0, 1, "R9 sync_done");
    want(0, "R9 load blocked in sync_done cycle");
    drive(1, 2'd0, 0, 0, 0, 0, 0, "R9 load after sync");
    want(1, "R9 load after sync complete");
    drain();

    // R10: saturation
    for (int i = 0; i < CMAX; i++) drive(1, 2'd0, 0, 0, 0, 0, 0, "R10 fill");
    drive(1, 2'd0, 0, 0, 0, 0, 0, "R10 full");
    want(0, "R10 load stalls at max count");
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R10 store free");
    want(1, "R10 store unaffected by load max");
    drain();

    // R11: spurious completions
    drive(0, 0, 0, 0, 1, 1, 1, "R11 spurious");
    drive(1, 2'd0, 0, 0, 0, 0, 0, "R11 load");
    want(1, "R11 load ready, count did not wrap");
    drive(1, 2'd2, 2'd0, 0, 0, 0, 0, "R11 fence");
    drive(1, 2'd1, 0, 0, 1, 0, 0, "R11 store waits");
    want(0, "R11 store waits on single load");
    drive(1, 2'd1, 0, 0, 0, 0, 0, "R11 store released");
    want(1, "R11 store after one ld_done");
    drain();

    // Random phases: frequent, then rare completions
    for (int ph = 0; ph < 2; ph++) begin
      int pd = (ph == 0) ? 50 : 6;
      for (int n = 0; n < 3000; n++) begin
        bit v = ($urandom % 100) < 75;
        bit [1:0] k = 2'($urandom % 4);
        bit [1:0] fk = 2'($urandom % 4);
        bit [3:0] mk = 4'($urandom % 16);
        bit ldd = (m_ld > 0) ? (($urandom % 100) < pd) : (($urandom % 100) < 3);
        bit std = (m_st > 0) ? (($urandom % 100) < pd) : (($urandom % 100) < 3);
        bit syd = m_busy ? (($urandom % 100) < 30) : (($urandom % 100) < 3);
        if (k == 2'd3 && ($urandom % 4) != 0) k = 2'd0;
        drive(v, k, fk, mk, ldd, std, syd, "R2-R12 random");
      end
      drain();
    end

    idle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule